// File: doc/BRIEF.md
# Clock Multiplier Control Sequencer

This block supervises an on-chip frequency multiplier that produces a clock four times faster than the oscillator. The analog multiplier itself lies outside the block. The block enables the multiplier, times how long it needs to settle, and moves the system clock between the two sources without glitches. A 4 MHz oscillator therefore becomes a 16 MHz core clock once software has completed the sequence.

Software uses two byte registers. The first is a settings register, selected with `regSel` = 1. It is written while the multiplier is stopped and chooses either a short or a long settling window. The second is a control register, selected with `regSel` = 0, and it holds a 2-bit command field. Writing the start command turns the multiplier on and starts a settling counter that runs on the oscillator. Software then polls a read-only busy bit in the same register. After the busy bit clears, software issues a separate switch command, and only that command moves `sysClk` to the fast source. A stop command always moves `sysClk` back to the oscillator before the multiplier is turned off.

The source change uses a two-stage synchronised handshake in each clock domain. The running source is released while it is low, and the new source is admitted only after the old one is confirmed off.

Top module: `clkmul_top`

## Requirements
- R1: After reset the control register reads 0x00, the settings register reads 0x00, `mulEnable` is 0 and `sysClk` has the oscillator period.
- R2: In the stopped state, a control write with bits [7:6] = 01 sets `mulEnable` to 1 and makes the control register read 0x60: the field reads 01 and busy bit 5 is 1.
- R3: The busy bit stays 1 for exactly 2^10 oscillator cycles when settings bit 0 is 0, and for exactly 2^12 cycles when it is 1. The count starts at the rising edge that accepts the start command. After that the control register reads 0x40.
- R4: Once settling has ended, a control write with bits [7:6] = 10 makes the control register read 0x80, and within a few cycles `sysClk` has one quarter of the oscillator period.
- R5: A switch command (10) given while stopped or while the busy bit is 1 is ignored: the register value and the oscillator-period `sysClk` are unchanged.
- R6: A stop command (00) given while settling or after settling, but before the switch, returns the control register to 0x00 and `mulEnable` to 0 at the next edge.
- R7: A stop command given while running keeps `mulEnable` at 1 until `sysClk` is back on the oscillator. After that the multiplier is disabled and the control register reads 0x00.
- R8: `sysClk` never shows a high or low phase shorter than half of a fast-clock period, and both sources are never gated through at the same time.
- R9: Code 11 has no effect. The start code has no effect outside the stopped state. Settings writes are ignored outside the stopped state, and their effect is seen by reading the settings register back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Oscillator clock; clocks all register logic |
| mulClk | input | 1 | Multiplied clock from the analog multiplier |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, sampled on the rising edge of oscClk |
| regSel | input | 1 | 0 selects the control register, 1 selects the settings register |
| regWrData | input | 8 | Write data; control uses bits [7:6], settings uses bit 0 |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| mulEnable | output | 1 | Enable to the analog multiplier |
| sysClk | output | 1 | Selected system clock |

## Verification
A settling counter that is off by one shows up as a busy bit whose length differs from the exact power of two. The bench counts that length cycle by cycle, so the error is seen on the first start command. A sequencer state that accepts a command too early or too late shows up at once in the control readback after the next write, or as a `sysClk` period that is wrong within a few cycles. A handshake that lets both sources through, or that drops the enable before the handoff, appears as a runt `sysClk` phase or as `mulEnable` falling while the fast source is still selected. Both are caught at the edge where they happen.

// File: rtl/clkmul_pkg.sv
`timescale 1ns/1ps
package clkmul_pkg;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_LOCK,
    ST_READY,
    ST_RUN,
    ST_DRAIN,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic wantMul;
    logic longLock;
  } dpCmd_t;

  localparam logic [1:0] CMD_STOP   = 2'b00;
  localparam logic [1:0] CMD_START  = 2'b01;
  localparam logic [1:0] CMD_SWITCH = 2'b10;

endpackage

// File: rtl/clkmul_ctrl.sv
`timescale 1ns/1ps
module clkmul_ctrl
  import clkmul_pkg::*;
(
  input  logic       oscClk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [7:0] regWrData,
  input  logic       cntDone,
  input  logic       oscOn,
  output dpCmd_t     cmd,
  output logic [7:0] regRdData,
  output logic       mulEnable,
  output logic       lockBusy,
  output seqState_t  stateQ
);

  seqState_t stateD;
  logic      longQ;
  logic      ctlWr;
  logic      setWr;
  logic [1:0] wrCode;
  logic [1:0] actField;
  logic      unusedWrBits;

  assign ctlWr  = regWrEn & ~regSel;
  assign setWr  = regWrEn & regSel;
  assign wrCode = regWrData[7:6];
  assign unusedWrBits = ^regWrData[5:1];

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_STOP:  if (ctlWr && wrCode == CMD_START) stateD = ST_LOCK;
      ST_LOCK:  if (ctlWr && wrCode == CMD_STOP) stateD = ST_STOP;
                else if (cntDone) stateD = ST_READY;
      ST_READY: if (ctlWr && wrCode == CMD_STOP) stateD = ST_STOP;
                else if (ctlWr && wrCode == CMD_SWITCH) stateD = ST_RUN;
      ST_RUN:   if (ctlWr && wrCode == CMD_STOP) stateD = ST_DRAIN;
      ST_DRAIN: stateD = ST_WAIT;
      ST_WAIT:  if (oscOn) stateD = ST_STOP;
      default:  stateD = ST_STOP;
    endcase
  end

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_STOP;
      longQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (setWr && stateQ == ST_STOP) longQ <= regWrData[0];
    end
  end

  always_comb begin
    unique case (stateQ)
      ST_STOP:                  actField = CMD_STOP;
      ST_LOCK, ST_READY:        actField = CMD_START;
      default:                  actField = CMD_SWITCH;
    endcase
  end

  assign lockBusy  = (stateQ == ST_LOCK);
  assign mulEnable = (stateQ != ST_STOP);
  assign regRdData = regSel ? {7'b0, longQ} : {actField, lockBusy, 5'b0};

  assign cmd.cntClear = (stateQ != ST_LOCK);
  assign cmd.cntStep  = (stateQ == ST_LOCK);
  assign cmd.wantMul  = (stateQ == ST_RUN);
  assign cmd.longLock = longQ;

endmodule

// File: rtl/clkmul_dp.sv
`timescale 1ns/1ps
module clkmul_dp
  import clkmul_pkg::*;
#(
  parameter int SHORT_LOG = 10,
  parameter int LONG_LOG  = 12,
  parameter int SYNC_LEN  = 2
) (
  input  logic   oscClk,
  input  logic   mulClk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   cntDone,
  output logic   oscOn,
  output logic   mulOn,
  output logic   sysClk
);

  localparam int CW = LONG_LOG;
  localparam logic [CW-1:0] SHORT_END = CW'((1 << SHORT_LOG) - 1);
  localparam logic [CW-1:0] LONG_END  = {CW{1'b1}};

  logic [CW-1:0]       lockCnt;
  logic [SYNC_LEN-1:0] oscPipe;
  logic [SYNC_LEN-1:0] mulPipe;

  // settling counter, oscillator domain
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) lockCnt <= '0;
    else if (cmd.cntClear) lockCnt <= '0;
    else if (cmd.cntStep) lockCnt <= lockCnt + CW'(1);
  end

  assign cntDone = (lockCnt == (cmd.longLock ? LONG_END : SHORT_END));

  // oscillator side of the handoff: admit only when fast path is confirmed off
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) oscPipe <= '1;
    else       oscPipe <= {oscPipe[SYNC_LEN-2:0], ~cmd.wantMul & ~mulOn};
  end

  always_ff @(negedge oscClk or negedge rstN) begin
    if (!rstN) oscOn <= 1'b1;
    else       oscOn <= oscPipe[SYNC_LEN-1];
  end

  // fast side of the handoff: admit only when oscillator path is confirmed off
  always_ff @(posedge mulClk or negedge rstN) begin
    if (!rstN) mulPipe <= '0;
    else       mulPipe <= {mulPipe[SYNC_LEN-2:0], cmd.wantMul & ~oscOn};
  end

  always_ff @(negedge mulClk or negedge rstN) begin
    if (!rstN) mulOn <= 1'b0;
    else       mulOn <= mulPipe[SYNC_LEN-1];
  end

  assign sysClk = (oscClk & oscOn) | (mulClk & mulOn);

endmodule

// File: rtl/clkmul_top.sv
`timescale 1ns/1ps
module clkmul_top
  import clkmul_pkg::*;
#(
  parameter int SHORT_LOG = 10,
  parameter int LONG_LOG  = 12
) (
  input  logic       oscClk,
  input  logic       mulClk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       mulEnable,
  output logic       sysClk
);

  dpCmd_t    cmd;
  seqState_t stateQ;
  logic      cntDone;
  logic      oscOn;
  logic      mulOn;
  logic      lockBusy;

  clkmul_ctrl uCtrl (
    .oscClk    (oscClk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .cntDone   (cntDone),
    .oscOn     (oscOn),
    .cmd       (cmd),
    .regRdData (regRdData),
    .mulEnable (mulEnable),
    .lockBusy  (lockBusy),
    .stateQ    (stateQ)
  );

  clkmul_dp #(
    .SHORT_LOG (SHORT_LOG),
    .LONG_LOG  (LONG_LOG),
    .SYNC_LEN  (2)
  ) uDp (
    .oscClk  (oscClk),
    .mulClk  (mulClk),
    .rstN    (rstN),
    .cmd     (cmd),
    .cntDone (cntDone),
    .oscOn   (oscOn),
    .mulOn   (mulOn),
    .sysClk  (sysClk)
  );

endmodule

// File: rtl/clkmul_chk.sv
`timescale 1ns/1ps
module clkmul_chk
  import clkmul_pkg::*;
(
  input logic      oscClk,
  input logic      mulClk,
  input logic      rstN,
  input logic      mulEnable,
  input logic      oscOn,
  input logic      mulOn,
  input logic      lockBusy,
  input seqState_t stateQ
);

  p_src_exclusive_r8: assert property (@(posedge mulClk) disable iff (!rstN)
    $onehot0({oscOn, mulOn}));

  p_osc_before_off_r7: assert property (@(posedge oscClk) disable iff (!rstN)
    $fell(mulEnable) |-> oscOn);

  p_busy_needs_enable_r2: assert property (@(posedge oscClk) disable iff (!rstN)
    lockBusy |-> mulEnable);

  p_run_after_ready_r5: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(stateQ == ST_RUN) |-> $past(stateQ) == ST_READY);

  p_fast_only_running_r4: assert property (@(posedge oscClk) disable iff (!rstN)
    mulOn |-> (stateQ == ST_RUN || stateQ == ST_DRAIN || stateQ == ST_WAIT));

endmodule

bind clkmul_top clkmul_chk uChk (
  .oscClk    (oscClk),
  .mulClk    (mulClk),
  .rstN      (rstN),
  .mulEnable (mulEnable),
  .oscOn     (oscOn),
  .mulOn     (mulOn),
  .lockBusy  (lockBusy),
  .stateQ    (stateQ)
);

// File: tb/tb_clkmul_top.sv
`timescale 1ns/1ps
module tb_clkmul_top;

  localparam int SHORT_LEN = 1 << 10;
  localparam int LONG_LEN  = 1 << 12;

  logic       oscClk = 1'b0;
  logic       mulClk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       mulEnable;
  logic       sysClk;

  int nChk = 0;
  int nBad = 0;
  int runts = 0;
  bit monOn = 1'b0;
  bit doneFlag = 1'b0;
  realtime lastEdge = 0.0;

  // bench model: 0 stop, 1 settling, 2 ready, 3 running, 4 draining
  int mState = 0;
  int mLeft = 0;
  bit mLong = 1'b0;

  clkmul_top dut (
    .oscClk(oscClk), .mulClk(mulClk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .mulEnable(mulEnable), .sysClk(sysClk)
  );

  always #10 oscClk = ~oscClk;
  initial begin
    #1.25;
    forever #2.5 mulClk = ~mulClk;
  end

  always @(sysClk) begin
    if (monOn && ($realtime - lastEdge) < 2.4) runts++;
    lastEdge = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expCtl(input int st);
    int act;
    act = (st == 0) ? 0 : ((st == 1 || st == 2) ? 1 : 2);
    return (act << 6) | ((st == 1) ? 32 : 0);
  endfunction

  function automatic int lockLen(input bit lng);
    return lng ? LONG_LEN : SHORT_LEN;
  endfunction

  task automatic advModel();
    if (mState == 1) begin
      mLeft--;
      if (mLeft == 0) mState = 2;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge oscClk);
      advModel();
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] data);
    int code;
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge oscClk);
    regWrEn = 1'b0; regSel = 1'b0;
    code = int'(data[7:6]);
    case (mState)
      0: if (sel) mLong = data[0];
         else if (code == 1) begin mState = 1; mLeft = lockLen(mLong); end
      1: if (!sel && code == 0) mState = 0; else advModel();
      2: if (!sel && code == 0) mState = 0;
         else if (!sel && code == 2) mState = 3;
      3: if (!sel && code == 0) mState = 4;
      default: ;
    endcase
  endtask

  task automatic readCtl(input string req);
    regSel = 1'b0; #1;
    check(int'(regRdData) == expCtl(mState), req, "control readback",
          int'(regRdData), expCtl(mState));
  endtask

  task automatic readSet(input string req);
    regSel = 1'b1; #1;
    check(int'(regRdData) == int'(mLong), req, "settings readback",
          int'(regRdData), int'(mLong));
    regSel = 1'b0;
  endtask

  task automatic period(input string req, input real exp);
    realtime t0, t1;
    @(posedge sysClk); t0 = $realtime;
    @(posedge sysClk); t1 = $realtime;
    check((t1 - t0) > exp - 0.1 && (t1 - t0) < exp + 0.1, req, "sysClk period x10ps",
          int'((t1 - t0) * 100), int'(exp * 100));
    @(negedge oscClk);
  endtask

  task automatic busyLen(input string req, input int exp);
    int n = 0;
    while (regRdData[5] && n < LONG_LEN + 10) begin
      n++;
      @(negedge oscClk);
    end
    check(n == exp, req, "busy length", n, exp);
    mState = 2;
  endtask

  task automatic stopFromRun();
    wr(1'b0, 8'h00);
    idle(30);
    mState = 0;
  endtask

  initial begin
    #3_000_000;
    nBad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    if (!doneFlag) $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge oscClk);
    rstN = 1'b1;
    @(negedge oscClk);
    monOn = 1'b1;

    // R1 reset state
    readCtl("R1");
    readSet("R1");
    check(mulEnable == 1'b0, "R1", "mulEnable", mulEnable, 0);
    period("R1", 20.0);

    // R5 switch while stopped
    wr(1'b0, 8'h80);
    readCtl("R5");
    period("R5", 20.0);

    // R2 start, R5 switch during settling, R3 short length
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h40);
    readCtl("R2");
    check(mulEnable == 1'b1, "R2", "mulEnable", mulEnable, 1);
    wr(1'b0, 8'h80);
    readCtl("R5");
    busyLen("R3", SHORT_LEN - 1);
    readCtl("R3");
    period("R5", 20.0);

    // R4 switch after settling
    wr(1'b0, 8'h80);
    readCtl("R4");
    idle(10);
    period("R4", 5.0);

    // R7 stop while running
    wr(1'b0, 8'h00);
    check(mulEnable == 1'b1, "R7", "mulEnable held during handoff", mulEnable, 1);
    idle(30);
    mState = 0;
    check(mulEnable == 1'b0, "R7", "mulEnable after handoff", mulEnable, 0);
    readCtl("R7");
    period("R7", 20.0);

    // R3 exact long length
    wr(1'b1, 8'h01);
    readSet("R3");
    wr(1'b0, 8'h40);
    busyLen("R3", LONG_LEN);
    readCtl("R3");

    // R9 ignored writes while ready
    wr(1'b1, 8'h00);
    readSet("R9");
    wr(1'b0, 8'hC0);
    readCtl("R9");
    wr(1'b0, 8'h40);
    readCtl("R9");

    // R6 stop from ready and from settling
    wr(1'b0, 8'h00);
    readCtl("R6");
    check(mulEnable == 1'b0, "R6", "mulEnable", mulEnable, 0);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h40);
    idle(5);
    wr(1'b0, 8'h00);
    readCtl("R6");
    check(mulEnable == 1'b0, "R6", "mulEnable", mulEnable, 0);

    // random mix, R9 and all state transitions
    for (int i = 0; i < 60; i++) begin
      int r = $urandom % 10;
      if (r < 6) begin
        logic [7:0] d = {2'($urandom % 4), 6'($urandom % 64)};
        if (mState == 3 && d[7:6] == 2'b00) stopFromRun();
        else wr(1'b0, d);
        readCtl("R9");
      end else if (r < 8) begin
        wr(1'b1, 8'($urandom % 256));
        readSet("R9");
        readCtl("R9");
      end else begin
        if (mState == 1) idle(mLeft + ($urandom % 3));
        else idle(10 + ($urandom % 20));
        readCtl("R3");
        if (mState == 3) period("R4", 5.0);
        else if (mState != 1) period("R1", 20.0);
      end
    end
    if (mState == 3) stopFromRun();
    period("R7", 20.0);

    check(runts == 0, "R8", "runt phases", runts, 0);
    doneFlag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule